// File: doc/BRIEF.md
# Channel Multiplicity, Majority and OR Logic

This block sits behind a bank of discriminator channels. Each cycle it receives the raw channel outputs and a per-channel enable mask. From these it forms three results. The first is a wide OR of every enabled channel that is active, driven both to a logic output and to a separate indicator output. The second is a digital hit count, which replaces an analogue current-sum signal. The third is a majority flag.

The majority flag compares a hit total against a level supplied in encoded form on the code input. Each level L is represented by the code NINT((50*L - 25)/4). The block decodes that code internally. In local mode the total is the on-chip count, which allows levels 1 to 16. In chained mode a multiplicity from neighbouring modules is added to the count, which extends the range to level 20.

All three results are registered together. Every output therefore shows the inputs of the previous clock cycle.

Top module: `mult_majority`

## Requirements
- R1: While rst_ni is low, or_o, or_led_o, mult_o and maj_o are all 0.
- R2: or_o is 1 in the cycle after at least one channel i had hit_i[i]=1 and enable_i[i]=1. Otherwise it is 0, so an active channel with its enable bit at 0 never raises it.
- R3: or_led_o carries the same value as or_o in every cycle.
- R4: mult_o equals, one cycle later, the number of channels with hit_i[i]=1 and enable_i[i]=1. The result runs from 0 to 16.
- R5: A code c decodes to the smallest level L with 50*L - 25 > 4*c - 2. For every level L from 1 to 20, the code NINT((50*L-25)/4) decodes back to L. For example, code 56 decodes to level 5 and code 244 to level 20.
- R6: maj_o is 1 in the cycle after the hit total is at least the decoded level, when the code is valid. It is 0 when the total is one below that level.
- R7: When ext_mode_i=0 (local mode), the hit total is the local count alone, and ext_mult_i has no effect on maj_o.
- R8: When ext_mode_i=1 (chained mode), the hit total is the local count plus the 5-bit ext_mult_i.
- R9: Code 0 holds maj_o low whatever the hits are. So does a code whose decoded level exceeds 16 in local mode (codes above 194) or 20 in chained mode (codes above 244).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hit_i | input | 16 | Discriminator outputs, one bit per channel |
| enable_i | input | 16 | Channel enable mask, 1 = channel counted |
| ext_mode_i | input | 1 | 1 = add the chained multiplicity to the total |
| ext_mult_i | input | 5 | Multiplicity from chained modules |
| maj_code_i | input | 8 | Encoded majority level |
| or_o | output | 1 | OR of enabled active channels, registered |
| or_led_o | output | 1 | Indicator copy of the OR |
| mult_o | output | 5 | Registered count of enabled active channels |
| maj_o | output | 1 | Registered majority flag |

## Verification
The assertions check several relations on every cycle:
- the OR output agrees with a non-zero count, and the indicator follows the OR;
- the count tracks the population of the previous cycle's masked inputs;
- code 0 and codes beyond the local limit never raise the majority flag;
- in local mode the flag never rises without a local hit.

Only the bench scenarios can show that the decoded level is exactly right. They sweep every level from 1 to 20 with totals of exactly L and L-1. They also show that the chained multiplicity is added in one mode and ignored in the other, and that the codes just past each mode's limit are rejected.

// File: rtl/mmaj_pkg.sv
package mmaj_pkg;

    // Default scaling of the encoded majority level: code = NINT((STEP*L - OFFS)/DIV)
    localparam int DEF_LVL_STEP = 50;
    localparam int DEF_LVL_OFFS = 25;
    localparam int DEF_LVL_DIV  = 4;

    // Encoded value of a level, rounded to nearest
    function automatic int level_to_code(input int level, input int step,
                                         input int offs, input int div);
        return (level * step - offs + div / 2) / div;
    endfunction

endpackage

// File: rtl/mm_popcount.sv
module mm_popcount #(
    parameter int N_CH  = 16,
    parameter int CNT_W = 5
) (
    input  logic [N_CH-1:0]  hit_i,
    input  logic [N_CH-1:0]  enable_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             any_o
);

    logic [N_CH-1:0] live;

    for (genvar g = 0; g < N_CH; g++) begin : g_mask
        assign live[g] = hit_i[g] & enable_i[g];
    end

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < N_CH; i++) begin
            cnt_o = cnt_o + CNT_W'(live[i]);
        end
    end

    assign any_o = |live;

endmodule

// File: rtl/mm_level_decode.sv
module mm_level_decode #(
    parameter int CODE_W   = 8,
    parameter int LVL_W    = 6,
    parameter int INT_MAX  = 16,
    parameter int EXT_MAX  = 20,
    parameter int LVL_STEP = 50,
    parameter int LVL_OFFS = 25,
    parameter int LVL_DIV  = 4
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              ext_mode_i,
    output logic [LVL_W-1:0]  level_o,
    output logic              valid_o
);

    // smallest L with STEP*L - OFFS > DIV*c - DIV/2
    localparam logic [31:0] BIAS = 32'(LVL_OFFS - LVL_DIV / 2);

    logic [31:0] scaled;
    logic [31:0] lvl_wide;
    logic [31:0] cap;

    always_comb begin
        scaled   = {{(32-CODE_W){1'b0}}, code_i} * 32'(LVL_DIV) + BIAS;
        lvl_wide = scaled / 32'(LVL_STEP) + 32'd1;
        cap      = ext_mode_i ? 32'(EXT_MAX) : 32'(INT_MAX);
        valid_o  = (code_i != '0) && (lvl_wide <= cap);
        level_o  = LVL_W'(lvl_wide);
    end

endmodule

// File: rtl/mult_majority.sv
module mult_majority #(
    parameter int N_CH     = 16,
    parameter int EXT_W    = 5,
    parameter int CODE_W   = 8,
    parameter int INT_MAX  = 16,
    parameter int EXT_MAX  = 20,
    parameter int LVL_STEP = mmaj_pkg::DEF_LVL_STEP,
    parameter int LVL_OFFS = mmaj_pkg::DEF_LVL_OFFS,
    parameter int LVL_DIV  = mmaj_pkg::DEF_LVL_DIV
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [N_CH-1:0]             hit_i,
    input  logic [N_CH-1:0]             enable_i,
    input  logic                        ext_mode_i,
    input  logic [EXT_W-1:0]            ext_mult_i,
    input  logic [CODE_W-1:0]           maj_code_i,
    output logic                        or_o,
    output logic                        or_led_o,
    output logic [$clog2(N_CH+1)-1:0]   mult_o,
    output logic                        maj_o
);

    localparam int CNT_W = $clog2(N_CH + 1);
    localparam int TOT_W = $clog2(N_CH + (1 << EXT_W));
    localparam int LVL_W = TOT_W;
    localparam int INT_CODE_MAX =
        mmaj_pkg::level_to_code(INT_MAX, LVL_STEP, LVL_OFFS, LVL_DIV);

    typedef struct packed {
        logic             any;
        logic             led;
        logic [CNT_W-1:0] cnt;
        logic             maj;
    } mm_state_t;

    mm_state_t st_d, st_q;

    logic [CNT_W-1:0] cnt_now;
    logic             any_now;
    logic [LVL_W-1:0] level;
    logic             level_ok;
    logic [TOT_W-1:0] total;

    mm_popcount #(
        .N_CH  (N_CH),
        .CNT_W (CNT_W)
    ) u_count (
        .hit_i    (hit_i),
        .enable_i (enable_i),
        .cnt_o    (cnt_now),
        .any_o    (any_now)
    );

    mm_level_decode #(
        .CODE_W   (CODE_W),
        .LVL_W    (LVL_W),
        .INT_MAX  (INT_MAX),
        .EXT_MAX  (EXT_MAX),
        .LVL_STEP (LVL_STEP),
        .LVL_OFFS (LVL_OFFS),
        .LVL_DIV  (LVL_DIV)
    ) u_decode (
        .code_i     (maj_code_i),
        .ext_mode_i (ext_mode_i),
        .level_o    (level),
        .valid_o    (level_ok)
    );

    always_comb begin
        total = TOT_W'(cnt_now);
        if (ext_mode_i) begin
            total = total + TOT_W'(ext_mult_i);
        end
        st_d.any = any_now;
        st_d.led = any_now;
        st_d.cnt = cnt_now;
        st_d.maj = level_ok && (total >= level);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign or_o     = st_q.any;
    assign or_led_o = st_q.led;
    assign mult_o   = st_q.cnt;
    assign maj_o    = st_q.maj;

    // R2: OR output agrees with a non-zero registered count
    a_r2_or_vs_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        or_o == (mult_o != '0));

    // R3: indicator follows the OR output
    a_r3_led_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        or_led_o == or_o);

    // R4: count equals last cycle's masked population
    a_r4_count_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mult_o == CNT_W'($countones($past(hit_i & enable_i))));

    // R7: in local mode the flag needs a local hit
    a_r7_local_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ext_mode_i |=> (!maj_o || or_o));

    // R9: code 0 never raises the flag
    a_r9_zero_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (maj_code_i == '0) |=> !maj_o);

    // R9: local mode rejects codes past its largest level
    a_r9_local_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ext_mode_i && (int'(maj_code_i) > INT_CODE_MAX)) |=> !maj_o);

endmodule

// File: tb/mult_majority_tb.sv
module mult_majority_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] hit = '0;
    logic [15:0] en = '0;
    logic        xmode = 1'b0;
    logic [4:0]  xmult = '0;
    logic [7:0]  code = '0;
    logic        or_o, led_o, maj_o;
    logic [4:0]  mult_o;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R6";

    int e_cnt;
    bit e_or, e_maj;

    always #2 clk = ~clk;

    mult_majority u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .hit_i      (hit),
        .enable_i   (en),
        .ext_mode_i (xmode),
        .ext_mult_i (xmult),
        .maj_code_i (code),
        .or_o       (or_o),
        .or_led_o   (led_o),
        .mult_o     (mult_o),
        .maj_o      (maj_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_level(input int c);
        for (int l = 1; l < 64; l++) begin
            if (50 * l - 25 > 4 * c - 2) return l;
        end
        return 64;
    endfunction

    function automatic int nint_code(input int l);
        real v;
        v = (50.0 * l - 25.0) / 4.0;
        return int'($floor(v + 0.5));
    endfunction

    // apply inputs, wait one edge, compare every output with the model
    task automatic step(input logic [15:0] h, input logic [15:0] m,
                        input logic xm, input logic [4:0] xv, input logic [7:0] c);
        int tot, lvl, cap;
        hit = h; en = m; xmode = xm; xmult = xv; code = c;
        e_cnt = 0;
        for (int i = 0; i < 16; i++) if (h[i] && m[i]) e_cnt++;
        e_or = (e_cnt != 0);
        tot = e_cnt + (xm ? int'(xv) : 0);
        lvl = ref_level(int'(c));
        cap = xm ? 20 : 16;
        e_maj = (c != 0) && (lvl <= cap) && (tot >= lvl);
        @(negedge clk);
        check("R2", "or_o", int'(or_o), int'(e_or));
        check("R3", "or_led_o", int'(led_o), int'(e_or));
        check("R4", "mult_o", int'(mult_o), e_cnt);
        check(tag, "maj_o", int'(maj_o), int'(e_maj));
    endtask

    function automatic logic [15:0] low_bits(input int k);
        return 16'((32'd1 << k) - 32'd1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        hit = 16'hFFFF; en = 16'hFFFF; code = 8'd6;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset despite active inputs
        check("R1", "or_o in reset", int'(or_o), 0);
        check("R1", "or_led_o in reset", int'(led_o), 0);
        check("R1", "mult_o in reset", int'(mult_o), 0);
        check("R1", "maj_o in reset", int'(maj_o), 0);
        hit = '0; en = '0; code = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R4: masked channels, including mask with channels 2 and 3 off
        tag = "R6";
        step(16'h000C, 16'hFFF3, 1'b0, 5'd0, 8'd6);
        step(16'h000F, 16'hFFF3, 1'b0, 5'd0, 8'd6);
        step(16'hFFFF, 16'h0000, 1'b0, 5'd0, 8'd6);
        step(16'hFFFF, 16'hFFFF, 1'b0, 5'd0, 8'd194);
        step(16'h8001, 16'h8000, 1'b0, 5'd0, 8'd6);

        // R5/R6/R8: every level round-trips; totals L and L-1
        tag = "R5";
        for (int l = 1; l <= 20; l++) begin
            int c;
            c = nint_code(l);
            check("R5", "level of NINT code", ref_level(c), l);
            if (l == 5) check("R5", "code for level 5", c, 56);
            if (l == 20) check("R5", "code for level 20", c, 244);
            step(low_bits(l > 16 ? 16 : l), 16'hFFFF, 1'b1,
                 5'(l > 16 ? l - 16 : 0), 8'(c));
            step(low_bits(l > 16 ? 15 : l - 1), 16'hFFFF, 1'b1,
                 5'(l > 16 ? l - 16 : 0), 8'(c));
        end

        // R8: chained count alone reaches the level
        tag = "R8";
        step(16'h0000, 16'hFFFF, 1'b1, 5'd5, 8'd56);
        step(16'h0003, 16'hFFFF, 1'b1, 5'd2, 8'd56);
        step(16'h0003, 16'hFFFF, 1'b1, 5'd3, 8'd56);

        // R7: local mode ignores the chained count
        tag = "R7";
        step(16'h0003, 16'hFFFF, 1'b0, 5'd31, 8'd31);
        step(16'h0000, 16'hFFFF, 1'b0, 5'd31, 8'd6);
        step(16'h0007, 16'hFFFF, 1'b0, 5'd31, 8'd31);

        // R9: invalid codes hold the flag low
        tag = "R9";
        step(16'hFFFF, 16'hFFFF, 1'b0, 5'd0, 8'd0);
        step(16'hFFFF, 16'hFFFF, 1'b1, 5'd31, 8'd0);
        step(16'hFFFF, 16'hFFFF, 1'b0, 5'd31, 8'd195);
        step(16'hFFFF, 16'hFFFF, 1'b1, 5'd31, 8'd245);
        step(16'hFFFF, 16'hFFFF, 1'b1, 5'd31, 8'd255);
        step(16'hFFFF, 16'hFFFF, 1'b1, 5'd31, 8'd195);

        // R6: mixed random traffic
        tag = "R6";
        for (int k = 0; k < 400; k++) begin
            step(16'($urandom), 16'($urandom), 1'($urandom), 5'($urandom),
                 8'($urandom_range(0, 255)));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule